// File: doc/BRIEF.md
# Tri-State Phase-Frequency Detector

This block compares the rising edges of a reference input against those of a feedback input and produces a three-level control for a clocked loop. The control can push up, push down or float. Both inputs may be asynchronous. Each input passes through a multi-stage synchronizer on a fast system clock, and a rising-edge detector then turns it into a pulse one clock long. Because only rising edges count, the duty cycle of either input has no effect on the result.

The core is a saturating three-state up/down counter. A reference edge moves it one step toward "up" and a feedback edge moves it one step toward "down". If both edges arrive in the same system clock the counter holds its value. When the two frequencies are equal, the active driver stays on for as long as the phase error lasts and the output floats after that. When one input runs faster, its driver stays on for most of each cycle. Averaged over time, the output follows the phase difference across plus or minus one full cycle, and the centre of that range is zero error, where the output floats. A phase-error flag and a signed occupancy count are provided so the loop can be observed.

Top module: `tri_pfd`

## Requirements
- R1: While `rst` is high on a rising clock edge, the block returns to the floating state. After that edge `upEn`, `dnEn`, `driveEn` and `phaseErr` are 0 and `occCount` is 2'b00.
- R2: A reference rising edge in the floating state sets `upEn`. The output changes on the (SYNC_STAGES+1)-th rising clock edge that samples `refIn` high, which is the third edge at the default of 2 stages.
- R3: A feedback edge while `upEn` is set, or a reference edge while `dnEn` is set, returns the block to the floating state.
- R4: A feedback rising edge in the floating state sets `dnEn`, with the same latency as R2.
- R5: The counter saturates. Further reference edges while `upEn` is set keep it set, and further feedback edges while `dnEn` is set keep that set. The counter never wraps to the opposite driver.
- R6: A reference edge and a feedback edge detected in the same system clock leave the state unchanged, so a driver that is already on stays on.
- R7: Only rising transitions count. A falling transition, or an input held high or low for any time, does not change the state.
- R8: `upEn` and `dnEn` are never both 1. `driveEn` equals `upEn` OR `dnEn`, and `phaseErr` is 1 exactly when `driveEn` is 1.
- R9: `occCount` is the signed counter value: 2'b01 for up (+1), 2'b00 for floating (0) and 2'b11 for down (-1). The code 2'b10 never appears.
- R10: When the reference runs faster than the feedback, `upEn` is on for far more cycles than `dnEn`. When the feedback runs faster, `dnEn` is on for far more cycles than `upEn`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than either input |
| rst | input | 1 | Synchronous active-high reset |
| refIn | input | 1 | Reference input, asynchronous |
| fbIn | input | 1 | Feedback input, asynchronous |
| upEn | output | 1 | Push-up driver enable |
| dnEn | output | 1 | Push-down driver enable |
| driveEn | output | 1 | Output is being driven; 0 means high impedance |
| phaseErr | output | 1 | A phase error is being driven |
| occCount | output | 2 | Signed counter occupancy: 01 = +1, 00 = 0, 11 = -1 |

## Verification
The assertions check the following on every cycle:
- the two drivers are mutually exclusive;
- the drive-enable and error flags agree with the driver enables;
- the occupancy code stays legal;
- each edge pulse lasts a single clock;
- the state holds when there is no edge or when edges coincide;
- the counter saturates and the up driver releases on a feedback edge.

Some behaviours can only be shown by the bench's scenarios: the exact synchronizer latency, indifference to falling edges and to input level, return to float after reset in the middle of a drive, and the dominance of one driver under a frequency mismatch.

// File: rtl/tri_pfd_pkg.sv
package tri_pfd_pkg;

  // Signed occupancy of the three-state counter.
  typedef enum logic [1:0] {
    OCC_ZERO = 2'b00,
    OCC_UP   = 2'b01,
    OCC_DOWN = 2'b11
  } occ_t;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic stepUp;
    logic stepDown;
  } strobe_t;

endpackage

// File: rtl/tri_pfd_edge.sv
module tri_pfd_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic asyncIn,
  output logic risePulse
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] chain;
  logic          prevLevel;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= asyncIn;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[LAST-1:0], asyncIn};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prevLevel <= 1'b0;
    else     prevLevel <= chain[LAST];
  end

  assign risePulse = chain[LAST] & ~prevLevel;
endmodule

// File: rtl/tri_pfd_ctrl.sv
module tri_pfd_ctrl
  import tri_pfd_pkg::*;
(
  input  logic    refEdge,
  input  logic    fbEdge,
  input  occ_t    occ,
  output strobe_t strobe
);
  logic onlyRef;
  logic onlyFb;

  always_comb begin
    onlyRef         = refEdge & ~fbEdge;
    onlyFb          = fbEdge & ~refEdge;
    strobe.stepUp   = onlyRef & (occ != OCC_UP);
    strobe.stepDown = onlyFb  & (occ != OCC_DOWN);
  end
endmodule

// File: rtl/tri_pfd_dp.sv
module tri_pfd_dp
  import tri_pfd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  strobe_t    strobe,
  output occ_t       occ,
  output logic       upEn,
  output logic       dnEn,
  output logic       driveEn,
  output logic       phaseErr,
  output logic [1:0] occCount
);
  occ_t occNext;

  always_comb begin
    occNext = occ;
    if (strobe.stepUp) begin
      case (occ)
        OCC_DOWN: occNext = OCC_ZERO;
        OCC_ZERO: occNext = OCC_UP;
        default:  occNext = occ;
      endcase
    end else if (strobe.stepDown) begin
      case (occ)
        OCC_UP:   occNext = OCC_ZERO;
        OCC_ZERO: occNext = OCC_DOWN;
        default:  occNext = occ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) occ <= OCC_ZERO;
    else     occ <= occNext;
  end

  always_comb begin
    upEn     = (occ == OCC_UP);
    dnEn     = (occ == OCC_DOWN);
    driveEn  = (occ != OCC_ZERO);
    phaseErr = occ[0];
    occCount = occ;
  end
endmodule

// File: rtl/tri_pfd.sv
module tri_pfd
  import tri_pfd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       refIn,
  input  logic       fbIn,
  output logic       upEn,
  output logic       dnEn,
  output logic       driveEn,
  output logic       phaseErr,
  output logic [1:0] occCount
);
  logic    refEdge;
  logic    fbEdge;
  occ_t    occ;
  strobe_t strobe;

  tri_pfd_edge #(.SYNC_STAGES(SYNC_STAGES)) u_refEdge (
    .clk(clk), .rst(rst), .asyncIn(refIn), .risePulse(refEdge)
  );

  tri_pfd_edge #(.SYNC_STAGES(SYNC_STAGES)) u_fbEdge (
    .clk(clk), .rst(rst), .asyncIn(fbIn), .risePulse(fbEdge)
  );

  tri_pfd_ctrl u_ctrl (
    .refEdge(refEdge), .fbEdge(fbEdge), .occ(occ), .strobe(strobe)
  );

  tri_pfd_dp u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .occ(occ),
    .upEn(upEn), .dnEn(dnEn), .driveEn(driveEn),
    .phaseErr(phaseErr), .occCount(occCount)
  );
endmodule

// File: rtl/tri_pfd_chk.sv
module tri_pfd_chk (
  input logic       clk,
  input logic       rst,
  input logic       refEdge,
  input logic       fbEdge,
  input logic       upEn,
  input logic       dnEn,
  input logic       driveEn,
  input logic       phaseErr,
  input logic [1:0] occCount
);
  a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(upEn && dnEn));

  a_r8_flags_agree: assert property (@(posedge clk) disable iff (rst)
    (driveEn == (upEn || dnEn)) && (phaseErr == driveEn));

  a_r9_legal_code: assert property (@(posedge clk) disable iff (rst)
    occCount != 2'b10);

  a_r6_coincident_hold: assert property (@(posedge clk) disable iff (rst)
    refEdge && fbEdge |=> $stable(occCount));

  a_r7_quiet_hold: assert property (@(posedge clk) disable iff (rst)
    !refEdge && !fbEdge |=> $stable(occCount));

  a_r7_ref_pulse_width: assert property (@(posedge clk) disable iff (rst)
    refEdge |=> !refEdge);

  a_r7_fb_pulse_width: assert property (@(posedge clk) disable iff (rst)
    fbEdge |=> !fbEdge);

  a_r5_up_saturates: assert property (@(posedge clk) disable iff (rst)
    upEn && refEdge && !fbEdge |=> upEn && occCount == 2'b01);

  a_r5_down_saturates: assert property (@(posedge clk) disable iff (rst)
    dnEn && fbEdge && !refEdge |=> dnEn && occCount == 2'b11);

  a_r3_up_release: assert property (@(posedge clk) disable iff (rst)
    upEn && fbEdge && !refEdge |=> !driveEn);

  a_r3_down_release: assert property (@(posedge clk) disable iff (rst)
    dnEn && refEdge && !fbEdge |=> !driveEn);
endmodule

bind tri_pfd tri_pfd_chk u_chk (
  .clk(clk), .rst(rst), .refEdge(refEdge), .fbEdge(fbEdge),
  .upEn(upEn), .dnEn(dnEn), .driveEn(driveEn),
  .phaseErr(phaseErr), .occCount(occCount)
);

// File: tb/test_tri_pfd.sv
`timescale 1ns/1ps
module test_tri_pfd;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic refIn = 1'b0;
  logic fbIn = 1'b0;
  logic upEn, dnEn, driveEn, phaseErr;
  logic [1:0] occCount;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  tri_pfd i_tri_pfd (
    .clk(clk), .rst(rst), .refIn(refIn), .fbIn(fbIn),
    .upEn(upEn), .dnEn(dnEn), .driveEn(driveEn),
    .phaseErr(phaseErr), .occCount(occCount)
  );

  // Vector fields: {ref pulse, fb pulse, expected up, expected down}
  localparam logic [3:0] VEC [10] = '{
    4'b1010, // R2 ref edge from float -> up
    4'b1010, // R5 ref edge while up -> stays up
    4'b0100, // R3 fb edge while up -> float
    4'b0101, // R4 fb edge from float -> down
    4'b0101, // R5 fb edge while down -> stays down
    4'b1101, // R6 coincident edges -> down holds
    4'b1000, // R3 ref edge while down -> float
    4'b1100, // R6 coincident edges in float -> float
    4'b1010, // R2 ref edge -> up
    4'b1110  // R6 coincident edges while up -> up holds
  };

  function automatic logic [5:0] expOf(input logic u, input logic d);
    logic [1:0] code;
    code = u ? 2'b01 : (d ? 2'b11 : 2'b00);
    return {u, d, u | d, u | d, code};
  endfunction

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [5:0] outs();
    return {upEn, dnEn, driveEn, phaseErr, occCount};
  endfunction

  task automatic pulse(input logic r, input logic f);
    @(negedge clk);
    refIn = r; fbIn = f;
    repeat (4) @(negedge clk);
    refIn = 1'b0; fbIn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic runFreq(input int refHalf, input int fbHalf, input int cycles,
                         output int upCyc, output int dnCyc);
    upCyc = 0; dnCyc = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if ((c % refHalf) == 0) refIn = ~refIn;
      if ((c % fbHalf) == 0) fbIn = ~fbIn;
      #1;
      if (upEn) upCyc++;
      if (dnEn) dnCyc++;
    end
    refIn = 1'b0; fbIn = 1'b0;
  endtask

  initial begin
    int upCyc, dnCyc;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset state", outs(), expOf(1'b0, 1'b0));

    for (int i = 0; i < 10; i++) begin
      pulse(VEC[i][3], VEC[i][2]);
      check($sformatf("R9 vector %0d", i), outs(), expOf(VEC[i][1], VEC[i][0]));
    end

    // R1: reset while up driver active
    doReset();
    check("R1 reset mid-drive", outs(), expOf(1'b0, 1'b0));

    // R2 latency: output changes on third sampling edge
    @(negedge clk); refIn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R2 latency before", outs(), expOf(1'b0, 1'b0));
    @(negedge clk);
    check("R2 latency after", outs(), expOf(1'b1, 1'b0));

    // R7: long high level, then falling edge, no change
    repeat (20) @(negedge clk);
    check("R7 held high level", outs(), expOf(1'b1, 1'b0));
    refIn = 1'b0;
    repeat (6) @(negedge clk);
    check("R7 falling ref edge", outs(), expOf(1'b1, 1'b0));
    pulse(1'b0, 1'b1);
    check("R3 release after hold", outs(), expOf(1'b0, 1'b0));

    // R7: feedback held high, falling edge ignored
    @(negedge clk); fbIn = 1'b1;
    repeat (25) @(negedge clk);
    check("R7 held fb level", outs(), expOf(1'b0, 1'b1));
    fbIn = 1'b0;
    repeat (6) @(negedge clk);
    check("R7 falling fb edge", outs(), expOf(1'b0, 1'b1));

    // R10: reference faster
    doReset();
    runFreq(10, 14, 1400, upCyc, dnCyc);
    total++;
    if (!(upCyc > 4 * dnCyc && upCyc > 200)) begin
      bad++;
      $display("FAIL R10 ref faster: up=%0d dn=%0d expected up>4*dn and up>200", upCyc, dnCyc);
    end

    // R10: feedback faster
    doReset();
    runFreq(14, 10, 1400, upCyc, dnCyc);
    total++;
    if (!(dnCyc > 4 * upCyc && dnCyc > 200)) begin
      bad++;
      $display("FAIL R10 fb faster: up=%0d dn=%0d expected dn>4*up and dn>200", upCyc, dnCyc);
    end

    doReset();
    check("R1 final reset", outs(), expOf(1'b0, 1'b0));

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule